// File: doc/BRIEF.md
# Delayed-Transfer Branch Unit

This block resolves control transfers for a 32-bit core whose architecture has one delay slot. For each retiring instruction it receives the instruction's PC, a decoded transfer kind, a signed word offset, a register operand, the condition flag, and the saved exception PC and status words. It returns the PC of the next instruction to execute, a link-register write, and a status-restore request.

A taken branch or jump does not redirect at once. The unit records the target and keeps the next sequential instruction, the delay slot, on the straight-line path. When that slot instruction retires, the recorded target becomes the next PC and the record is cleared. Return-from-exception is not deferred. It redirects to the saved exception PC in the same cycle and asks the status register to reload from the saved status word.

Top module: `branch_unit`

## Requirements
- R1: After reset `pending_o` is 0 and `pending_target_o` is 0.
- R2: Transfer kind codes are 0 none, 1 branch-if-flag, 2 branch-if-not-flag, 3 jump, 4 jump-and-link, 5 jump-register, 6 jump-and-link-register, 7 return-from-exception. Kind 1 is taken when `flag_i` is 1, kind 2 when `flag_i` is 0, and kinds 3 to 6 are always taken. A taken transfer outside a delay slot sets `pending_o` after the clock edge.
- R3: For kinds 1 to 4, the recorded target is `pc_i` plus the sign-extended `offset_i` multiplied by 4, modulo 2^XLEN.
- R4: A kind-1 or kind-2 branch that is not taken, and a kind-0 instruction, leave `pending_o` at 0 and give `next_pc_o` = `pc_i` + 4.
- R5: For kinds 5 and 6, the recorded target is `reg_target_i`.
- R6: For kinds 4 and 6 outside a delay slot, `link_we_o` is 1 in the same cycle, with `link_idx_o` = 9 and `link_data_o` = `pc_i` + 8.
- R7: While a taken transfer retires, `next_pc_o` is `pc_i` + 4. While the next valid instruction (the delay slot) retires, `next_pc_o` equals `pending_target_o`, and `pending_o` is 0 after that edge.
- R8: Kind 7 outside a delay slot gives `next_pc_o` = `epc_i`, `sr_restore_o` = 1 and `sr_value_o` = `esr_i` in the same cycle, and it does not set `pending_o`.
- R9: Any transfer kind in a delay slot is suppressed: no link write, no status restore, and no new pending target.
- R10: With `valid_i` low, `pending_o` and `pending_target_o` hold, and `link_we_o` and `sr_restore_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction retires this cycle |
| pc_i | input | XLEN | PC of the retiring instruction |
| br_kind_i | input | 3 | Transfer kind code |
| offset_i | input | OFF_W | Signed word offset |
| reg_target_i | input | XLEN | Register operand used as target |
| flag_i | input | 1 | Condition flag |
| epc_i | input | XLEN | Saved exception PC |
| esr_i | input | SR_W | Saved exception status |
| next_pc_o | output | XLEN | PC of the next instruction to execute |
| pending_o | output | 1 | A deferred target is recorded |
| pending_target_o | output | XLEN | Recorded deferred target |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | REG_W | Link register index |
| link_data_o | output | XLEN | Link register write value |
| sr_restore_o | output | 1 | Status register restore request |
| sr_value_o | output | SR_W | Value to restore into status |

## Verification
The bench builds the unit with XLEN = 12, OFF_W = 6 and SR_W = 4. With these widths it sweeps all 64 offsets against every transfer kind and both flag values, so both signs of the offset are covered and relative targets wrap across the top of the address space. Every transfer kind is also placed in the delay slot of a taken transfer. A pause with `valid_i` low between a transfer and its slot checks that the recorded target is held.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [2:0] {
    BRU_NONE = 3'd0,
    BRU_BF   = 3'd1,
    BRU_BNF  = 3'd2,
    BRU_J    = 3'd3,
    BRU_JAL  = 3'd4,
    BRU_JR   = 3'd5,
    BRU_JALR = 3'd6,
    BRU_RFE  = 3'd7
  } bru_kind_e;

  typedef struct packed {
    logic taken;
    logic use_reg;
    logic link;
    logic rfe;
  } bru_ctl_t;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [2:0] kind_i,
  input  logic       flag_i,
  output bru_ctl_t   ctl_o
);
  bru_kind_e kind;
  assign kind = bru_kind_e'(kind_i);

  always_comb begin
    ctl_o = '0;
    unique case (kind)
      BRU_BF:   ctl_o.taken = flag_i;
      BRU_BNF:  ctl_o.taken = ~flag_i;
      BRU_J:    ctl_o.taken = 1'b1;
      BRU_JAL:  begin ctl_o.taken = 1'b1; ctl_o.link = 1'b1; end
      BRU_JR:   begin ctl_o.taken = 1'b1; ctl_o.use_reg = 1'b1; end
      BRU_JALR: begin ctl_o.taken = 1'b1; ctl_o.use_reg = 1'b1; ctl_o.link = 1'b1; end
      BRU_RFE:  ctl_o.rfe = 1'b1;
      default:  ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 26,
  parameter int unsigned ISTEP = 4
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [XLEN-1:0]  rel_tgt_o,
  output logic [XLEN-1:0]  seq_pc_o,
  output logic [XLEN-1:0]  link_pc_o
);
  localparam int unsigned SHIFT = $clog2(ISTEP);
  localparam int unsigned EXT_W = XLEN - OFF_W;

  logic [XLEN-1:0] off_sx;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_sx = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    end else begin : g_trunc
      assign off_sx = offset_i[XLEN-1:0];
    end
  endgenerate

  assign rel_tgt_o = pc_i + (off_sx << SHIFT);
  assign seq_pc_o  = pc_i + XLEN'(ISTEP);
  assign link_pc_o = pc_i + XLEN'(2 * ISTEP);
endmodule

// File: rtl/bru_delay.sv
module bru_delay #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            load_i,
  input  logic [XLEN-1:0] tgt_i,
  output logic            pend_o,
  output logic [XLEN-1:0] tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      tgt_o  <= '0;
    end else if (adv_i) begin
      if (pend_o) begin
        pend_o <= 1'b0;   // delay slot retired, redirect consumed
      end else if (load_i) begin
        pend_o <= 1'b1;
        tgt_o  <= tgt_i;
      end
    end
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import bru_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned OFF_W    = 26,
  parameter int unsigned SR_W     = 16,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned LINK_IDX = 9,
  parameter int unsigned ISTEP    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [2:0]        br_kind_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [XLEN-1:0]   reg_target_i,
  input  logic              flag_i,
  input  logic [XLEN-1:0]   epc_i,
  input  logic [SR_W-1:0]   esr_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              pending_o,
  output logic [XLEN-1:0]   pending_target_o,
  output logic              link_we_o,
  output logic [REG_W-1:0]  link_idx_o,
  output logic [XLEN-1:0]   link_data_o,
  output logic              sr_restore_o,
  output logic [SR_W-1:0]   sr_value_o
);
  bru_ctl_t        ctl;
  logic [XLEN-1:0] rel_tgt, seq_pc, link_pc, new_tgt;
  logic            in_slot, act;

  bru_decode u_dec (
    .kind_i (br_kind_i),
    .flag_i (flag_i),
    .ctl_o  (ctl)
  );

  bru_target #(.XLEN(XLEN), .OFF_W(OFF_W), .ISTEP(ISTEP)) u_tgt (
    .pc_i      (pc_i),
    .offset_i  (offset_i),
    .rel_tgt_o (rel_tgt),
    .seq_pc_o  (seq_pc),
    .link_pc_o (link_pc)
  );

  assign new_tgt = ctl.use_reg ? reg_target_i : rel_tgt;

  bru_delay #(.XLEN(XLEN)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (valid_i),
    .load_i (ctl.taken),
    .tgt_i  (new_tgt),
    .pend_o (pending_o),
    .tgt_o  (pending_target_o)
  );

  assign in_slot = pending_o;
  assign act     = valid_i & ~in_slot;

  always_comb begin
    if (in_slot)      next_pc_o = pending_target_o;
    else if (ctl.rfe) next_pc_o = epc_i;
    else              next_pc_o = seq_pc;
  end

  assign link_we_o    = act & ctl.link;
  assign link_idx_o   = REG_W'(LINK_IDX);
  assign link_data_o  = link_pc;
  assign sr_restore_o = act & ctl.rfe;
  assign sr_value_o   = esr_i;
endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned OFF_W    = 26,
  parameter int unsigned SR_W     = 16,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned LINK_IDX = 9,
  parameter int unsigned ISTEP    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [2:0]        br_kind_i,
  input logic              flag_i,
  input logic [XLEN-1:0]   reg_target_i,
  input logic [XLEN-1:0]   epc_i,
  input logic [SR_W-1:0]   esr_i,
  input logic [XLEN-1:0]   next_pc_o,
  input logic              pending_o,
  input logic [XLEN-1:0]   pending_target_o,
  input logic              link_we_o,
  input logic [REG_W-1:0]  link_idx_o,
  input logic [XLEN-1:0]   link_data_o,
  input logic              sr_restore_o,
  input logic [SR_W-1:0]   sr_value_o
);
  assert_taken_bf_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pending_o && br_kind_i == 3'd1 && flag_i |=> pending_o);

  assert_nottaken_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pending_o && br_kind_i == 3'd2 && flag_i |=> !pending_o);

  assert_reg_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pending_o && br_kind_i == 3'd5 |=> pending_target_o == $past(reg_target_i));

  assert_link_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> link_idx_o == REG_W'(LINK_IDX) && link_data_o == pc_i + XLEN'(2 * ISTEP));

  assert_slot_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pending_o |=> !pending_o);

  assert_slot_pc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> next_pc_o == pending_target_o);

  assert_rfe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_restore_o |-> next_pc_o == epc_i && sr_value_o == esr_i);

  assert_slot_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> !link_we_o && !sr_restore_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pending_o) && $stable(pending_target_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !link_we_o && !sr_restore_o);
endmodule

bind branch_unit branch_unit_chk #(
  .XLEN(XLEN), .OFF_W(OFF_W), .SR_W(SR_W), .REG_W(REG_W),
  .LINK_IDX(LINK_IDX), .ISTEP(ISTEP)
) chk_i (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .valid_i          (valid_i),
  .pc_i             (pc_i),
  .br_kind_i        (br_kind_i),
  .flag_i           (flag_i),
  .reg_target_i     (reg_target_i),
  .epc_i            (epc_i),
  .esr_i            (esr_i),
  .next_pc_o        (next_pc_o),
  .pending_o        (pending_o),
  .pending_target_o (pending_target_o),
  .link_we_o        (link_we_o),
  .link_idx_o       (link_idx_o),
  .link_data_o      (link_data_o),
  .sr_restore_o     (sr_restore_o),
  .sr_value_o       (sr_value_o)
);

// File: tb/branch_unit_tb_top.sv
module branch_unit_tb_top;
  localparam int XLEN  = 12;
  localparam int OFF_W = 6;
  localparam int SR_W  = 4;
  localparam int REG_W = 5;
  localparam int MASK  = (1 << XLEN) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid;
  logic [XLEN-1:0]  pc, regt, epc, next_pc, ptgt, ldata;
  logic [2:0]       kind;
  logic [OFF_W-1:0] off;
  logic             flag, pend, lwe, srr;
  logic [SR_W-1:0]  esr, srv;
  logic [REG_W-1:0] lidx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  branch_unit #(.XLEN(XLEN), .OFF_W(OFF_W), .SR_W(SR_W), .REG_W(REG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pc_i(pc), .br_kind_i(kind),
    .offset_i(off), .reg_target_i(regt), .flag_i(flag), .epc_i(epc), .esr_i(esr),
    .next_pc_o(next_pc), .pending_o(pend), .pending_target_o(ptgt),
    .link_we_o(lwe), .link_idx_o(lidx), .link_data_o(ldata),
    .sr_restore_o(srr), .sr_value_o(srv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int k, input int p, input int o,
                       input int r, input bit f, input int e, input int s);
    @(negedge clk);
    valid = v; kind = 3'(k); pc = XLEN'(p); off = OFF_W'(o);
    regt = XLEN'(r); flag = f; epc = XLEN'(e); esr = SR_W'(s);
    #2;
  endtask

  function automatic bit is_taken(input int k, input bit f);
    return (k == 1 && f) || (k == 2 && !f) || (k >= 3 && k <= 6);
  endfunction

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    valid = 0; kind = 0; pc = 0; off = 0; regt = 0; flag = 0; epc = 0; esr = 0;
    #22;
    chk(pend == 1'b0, "R1 pending", int'(pend), 0);
    chk(ptgt == '0, "R1 target", int'(ptgt), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++) begin
      for (int f = 0; f < 2; f++) begin
        for (int o = 0; o < 64; o++) begin
          int p, r, e, s, sof, exp_t, slot_k;
          bit tk;
          p = ((o * 68) + (k * 4) + 'hF00) & MASK & ~3;
          r = (~p) & MASK;
          e = (p ^ 'h555) & MASK;
          s = (o + k) & 15;
          sof = (o >= 32) ? o - 64 : o;
          tk = is_taken(k, f[0]);
          exp_t = (k == 5 || k == 6) ? r : ((p + sof * 4) & MASK);
          // transfer instruction
          drive(1'b1, k, p, o, r, f[0], e, s);
          if (k == 7) begin
            chk(next_pc == XLEN'(e), "R8 next_pc", int'(next_pc), e);
            chk(srr == 1'b1 && srv == SR_W'(s), "R8 restore", int'({srr, srv}), (1 << SR_W) | s);
          end else begin
            chk(next_pc == XLEN'((p + 4) & MASK), "R7 R4 next_pc", int'(next_pc), (p + 4) & MASK);
            chk(srr == 1'b0, "R8 no restore", int'(srr), 0);
          end
          if (k == 4 || k == 6)
            chk(lwe && lidx == 5'd9 && ldata == XLEN'((p + 8) & MASK), "R6 link",
                int'(ldata), (p + 8) & MASK);
          else
            chk(lwe == 1'b0, "R6 no link", int'(lwe), 0);
          // optional pause with side-effect kinds idle
          if (o == 5) begin
            drive(1'b0, 4, p, o, r, f[0], e, s);
            chk(lwe == 1'b0 && srr == 1'b0, "R10 idle quiet", int'({lwe, srr}), 0);
            drive(1'b0, 7, p, o, 0, f[0], e, s);
            chk(pend == tk, "R10 hold pending", int'(pend), int'(tk));
            if (tk) chk(ptgt == XLEN'(exp_t), "R10 hold target", int'(ptgt), exp_t);
          end
          // slot / next instruction
          slot_k = tk ? (o % 8) : 0;
          drive(1'b1, slot_k, (p + 4) & MASK, o ^ 21, r ^ 1, ~f[0], e, s);
          if (tk) begin
            chk(pend == 1'b1, "R2 pending", int'(pend), 1);
            chk(ptgt == XLEN'(exp_t), (k >= 5) ? "R5 target" : "R3 target", int'(ptgt), exp_t);
            chk(next_pc == XLEN'(exp_t), "R7 slot next_pc", int'(next_pc), exp_t);
            chk(lwe == 1'b0 && srr == 1'b0, "R9 slot suppressed", int'({lwe, srr}), 0);
          end else begin
            chk(pend == 1'b0, "R4 R8 no pending", int'(pend), 0);
            chk(next_pc == XLEN'((p + 8) & MASK), "R4 seq next_pc", int'(next_pc), (p + 8) & MASK);
          end
          drive(1'b0, 0, 0, 0, 0, 1'b0, 0, 0);
          chk(pend == 1'b0, tk ? "R7 R9 cleared" : "R4 idle", int'(pend), 0);
        end
      end
    end

    // async reset while pending
    drive(1'b1, 3, 'h100, 3, 0, 1'b0, 0, 0);
    drive(1'b0, 0, 0, 0, 0, 1'b0, 0, 0);
    rst_n = 1'b0;
    #1;
    chk(pend == 1'b0 && ptgt == '0, "R1 async reset", int'(ptgt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule